// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day for precision time stamping. The time is a 32-bit seconds count and a 31-bit sub-second count, and the block advances the sub-second count on its own clock. Two advance schemes are available. In the coarse scheme, a programmed step is added on every clock. In the fine scheme, a 32-bit addend is accumulated every clock, and the step is added only when that accumulation carries out. The addend sets the frequency trim, so the advance rate can be tuned finely. The sub-second count rolls over either at one billion (a decimal nanosecond count) or at 2^31 (binary fractions of roughly 0.465 ns). Each rollover carries into the seconds count.

Software drives the block through a plain register write port and a combinational read port. It stages a new time, an offset or an addend in holding registers. It then sets a command bit in the control register. Each command bit clears itself on the clock edge that performs the command. A time load replaces the running time. An offset adds the staged seconds and sub-seconds to the running time. To subtract, software stages the complements of the amounts and sets a sign flag, and the block then borrows from seconds instead of carrying. An addend load moves the staged addend into the accumulator. The two time outputs are plain control-style pins and carry no handshake.

Register map (word addresses): 0 control, 1 step, 2 staged seconds, 3 staged sub-seconds with the sign flag in bit 31, 4 staged addend, 5 time seconds (read only), 6 time sub-seconds (read only). Control bits: bit 0 selects fine mode, bit 1 selects decimal rollover, bit 2 requests a time load, bit 3 requests an offset, bit 4 requests an addend load. Writing a 1 to a command bit sets it. Writing a 0 does not cancel a pending command.

Top module: `ptp_tod_top`

## Requirements
- R1: After reset, both time outputs read 0. Reading the control register returns 0.
- R2: In coarse mode (control bit 0 = 0), the step (register 1, bits 7:0) is added to the sub-seconds on every clock. In decimal rollover (control bit 1 = 1), a sum of at least 1,000,000,000 wraps by that amount and adds 1 to seconds. A step of 0 holds the time.
- R3: In binary rollover (control bit 1 = 0), the sub-seconds wrap at 2^31 and carry 1 into seconds.
- R4: In fine mode (control bit 0 = 1), the active addend is added to a 32-bit accumulator every clock. The step is applied only on clocks where that sum carries out. An addend of 2^31 applies the step on every second clock.
- R5: Setting control bit 2 makes the next clock load seconds from register 2 and sub-seconds from register 3 bits 30:0. The bit reads 1 for exactly the one cycle between the write and the load.
- R6: A write to register 4 has no effect on the advance until control bit 4 is set. The next clock then copies the staged addend into the accumulator path and clears the bit.
- R7: Setting control bit 3 with register 3 bit 31 = 0 adds the staged seconds and sub-seconds to the time, with a carry into seconds when the sub-seconds wrap.
- R8: With register 3 bit 31 = 1, the offset is a subtract. The staged seconds hold 2^32 minus the seconds to remove, and the staged sub-seconds hold the rollover value minus the sub-seconds to remove. The result takes 1 from seconds when the sub-second sum does not wrap.
- R9: If several command bits are pending, one command runs per clock in the order time load, then offset, then addend load. Each bit clears on the clock that performs its command.
- R10: On a clock that performs a time load or an offset, the normal step is not added.
- R11: Seconds and sub-seconds change on the same clock edge. Outside the load and offset commands, seconds change only when the sub-seconds wrap, and then by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| tod_sec | output | 32 | Current seconds |
| tod_subsec | output | 31 | Current sub-seconds |

## Verification
The assertions assume that the running sub-second value is always below the rollover value of the mode in use. They also assume that staged sub-second values are in range, and that a binary-mode subtract never removes zero sub-seconds, because the full complement does not fit in 31 bits. The stimulus loads only in-range times. It changes the rollover mode only while the time is small or about to be reloaded, and it uses nonzero sub-second amounts in every subtract. The step is held at 0 while holding registers are rewritten, except in the sequences that check step suppression, where each write clock's step is counted in the expected values.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_STEP   = 3'd1,
    A_SECSTG = 3'd2,
    A_SUBSTG = 3'd3,
    A_ADDSTG = 3'd4,
    A_TSEC   = 3'd5,
    A_TSUB   = 3'd6
  } reg_addr_e;

  localparam int CB_FINE = 0;
  localparam int CB_DEC  = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_OFFS = 3;
  localparam int CB_ADDL = 4;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_OFFS = 2'd2,
    CMD_ADDL = 2'd3
  } cmd_e;
endpackage

// File: rtl/ptp_tod_wrapadd.sv
module ptp_tod_wrapadd #(
  parameter int SUB_W = 31,
  parameter longint unsigned DEC_ROLL = 64'd1_000_000_000
) (
  input  logic             dec_mode,
  input  logic [SUB_W-1:0] a,
  input  logic [SUB_W-1:0] b,
  output logic [SUB_W-1:0] sum,
  output logic             wrap
);
  localparam logic [SUB_W:0] ROLL_V = (SUB_W+1)'(DEC_ROLL);

  logic [SUB_W:0] raw;
  logic [SUB_W:0] red;

  assign raw = {1'b0, a} + {1'b0, b};
  assign red = raw - ROLL_V;

  always_comb begin
    if (dec_mode) begin
      wrap = (raw >= ROLL_V);
      sum  = wrap ? red[SUB_W-1:0] : raw[SUB_W-1:0];
    end else begin
      wrap = raw[SUB_W];
      sum  = raw[SUB_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int ADD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic             load,
  input  logic [ADD_W-1:0] load_val,
  output logic             tick
);
  logic [ADD_W-1:0] acc_q;
  logic [ADD_W-1:0] act_q;
  logic [ADD_W:0]   nxt;

  assign nxt  = {1'b0, acc_q} + {1'b0, act_q};
  assign tick = fine_mode ? nxt[ADD_W] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      act_q <= '0;
    end else begin
      if (fine_mode) acc_q <= nxt[ADD_W-1:0];
      if (load)      act_q <= load_val;
    end
  end
endmodule

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8,
  parameter int ADD_W = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [SUB_W-1:0] tod_sub,
  output logic             fine_mode,
  output logic             dec_mode,
  output logic [INC_W-1:0] step,
  output logic [SEC_W-1:0] sec_stg,
  output logic [SUB_W-1:0] sub_stg,
  output logic             neg_stg,
  output logic [ADD_W-1:0] add_stg,
  output cmd_e             cmd
);
  logic pend_load, pend_offs, pend_addl;

  always_comb begin
    if (pend_load)      cmd = CMD_LOAD;
    else if (pend_offs) cmd = CMD_OFFS;
    else if (pend_addl) cmd = CMD_ADDL;
    else                cmd = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_mode <= 1'b0;
      dec_mode  <= 1'b0;
      pend_load <= 1'b0;
      pend_offs <= 1'b0;
      pend_addl <= 1'b0;
      step      <= '0;
      sec_stg   <= '0;
      sub_stg   <= '0;
      neg_stg   <= 1'b0;
      add_stg   <= '0;
    end else begin
      case (cmd)
        CMD_LOAD: pend_load <= 1'b0;
        CMD_OFFS: pend_offs <= 1'b0;
        CMD_ADDL: pend_addl <= 1'b0;
        default:  ;
      endcase
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            fine_mode <= wr_data[CB_FINE];
            dec_mode  <= wr_data[CB_DEC];
            if (wr_data[CB_LOAD]) pend_load <= 1'b1;
            if (wr_data[CB_OFFS]) pend_offs <= 1'b1;
            if (wr_data[CB_ADDL]) pend_addl <= 1'b1;
          end
          A_STEP:   step    <= wr_data[INC_W-1:0];
          A_SECSTG: sec_stg <= wr_data[SEC_W-1:0];
          A_SUBSTG: begin
            sub_stg <= wr_data[SUB_W-1:0];
            neg_stg <= wr_data[DW-1];
          end
          A_ADDSTG: add_stg <= wr_data[ADD_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = DW'({pend_addl, pend_offs, pend_load, dec_mode, fine_mode});
      A_STEP:   rd_data = DW'(step);
      A_SECSTG: rd_data = DW'(sec_stg);
      A_SUBSTG: rd_data = {neg_stg, (DW-1)'(sub_stg)};
      A_ADDSTG: rd_data = DW'(add_stg);
      A_TSEC:   rd_data = DW'(tod_sec);
      A_TSUB:   rd_data = DW'(tod_sub);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ptp_tod_top.sv
module ptp_tod_top
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8,
  parameter int ADD_W = 32,
  parameter int DW    = 32,
  parameter longint unsigned DEC_ROLL = 64'd1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [31:0]      tod_sec,
  output logic [30:0]      tod_subsec
);
  localparam int PAD_W = SUB_W - INC_W;

  logic             fine_mode, dec_mode, neg_stg, tick;
  logic [INC_W-1:0] step;
  logic [SEC_W-1:0] sec_stg;
  logic [SUB_W-1:0] sub_stg;
  logic [ADD_W-1:0] add_stg;
  cmd_e             cmd;
  logic             exec_load, exec_offs;
  logic [SUB_W-1:0] step_sum, offs_sum;
  logic             step_wrap, offs_wrap;
  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;

  assign exec_load  = (cmd == CMD_LOAD);
  assign exec_offs  = (cmd == CMD_OFFS);
  assign tod_sec    = sec_q;
  assign tod_subsec = sub_q;

  ptp_tod_regs #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .ADD_W(ADD_W), .DW(DW)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tod_sec(sec_q), .tod_sub(sub_q),
    .fine_mode(fine_mode), .dec_mode(dec_mode), .step(step),
    .sec_stg(sec_stg), .sub_stg(sub_stg), .neg_stg(neg_stg),
    .add_stg(add_stg), .cmd(cmd)
  );

  ptp_tod_accum #(.ADD_W(ADD_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode),
    .load(cmd == CMD_ADDL), .load_val(add_stg), .tick(tick)
  );

  ptp_tod_wrapadd #(.SUB_W(SUB_W), .DEC_ROLL(DEC_ROLL)) step_add_i (
    .dec_mode(dec_mode), .a(sub_q), .b({{PAD_W{1'b0}}, step}),
    .sum(step_sum), .wrap(step_wrap)
  );

  ptp_tod_wrapadd #(.SUB_W(SUB_W), .DEC_ROLL(DEC_ROLL)) offs_add_i (
    .dec_mode(dec_mode), .a(sub_q), .b(sub_stg),
    .sum(offs_sum), .wrap(offs_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (exec_load) begin
      sec_q <= sec_stg;
      sub_q <= sub_stg;
    end else if (exec_offs) begin
      sec_q <= sec_q + sec_stg + SEC_W'(offs_wrap) - SEC_W'(neg_stg);
      sub_q <= offs_sum;
    end else if (tick) begin
      sec_q <= sec_q + SEC_W'(step_wrap);
      sub_q <= step_sum;
    end
  end
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] tod_sec,
  input logic [SUB_W-1:0] tod_subsec,
  input logic             exec_load,
  input logic             exec_offs,
  input logic             tick,
  input logic             fine_mode,
  input logic             dec_mode,
  input logic [INC_W-1:0] step,
  input logic [SEC_W-1:0] sec_stg,
  input logic [SUB_W-1:0] sub_stg
);
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_load |=> (tod_sec == $past(sec_stg)) && (tod_subsec == $past(sub_stg))); // R5

  AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_load && !exec_offs && !fine_mode && !dec_mode) |=>
      tod_subsec == SUB_W'($past(tod_subsec) + SUB_W'($past(step)))); // R3

  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_mode && !tick && !exec_load && !exec_offs) |=>
      ($stable(tod_sec) && $stable(tod_subsec))); // R4

  AST_SEC_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_load && !exec_offs) |=>
      ((tod_sec == $past(tod_sec)) || (tod_subsec < $past(tod_subsec)))); // R11

  AST_SEC_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_load && !exec_offs) |=> (SEC_W'(tod_sec - $past(tod_sec)) <= 1)); // R2
endmodule

bind ptp_tod_top ptp_tod_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tod_sec(sec_q), .tod_subsec(sub_q),
  .exec_load(exec_load), .exec_offs(exec_offs), .tick(tick),
  .fine_mode(fine_mode), .dec_mode(dec_mode), .step(step),
  .sec_stg(sec_stg), .sub_stg(sub_stg)
);

// File: tb/ptp_tod_top_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_top_tb_top;
  localparam int RC = 0, RS = 1, RSEC = 2, RSUB = 3, RADD = 4, RTS = 5, RTN = 6;
  localparam logic [31:0] BIL = 32'd1_000_000_000;

  typedef struct {
    string       req;
    logic [31:0] s;
    logic [30:0] ns;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] tod_sec;
  logic [30:0] tod_subsec;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  ptp_tod_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tod_sec(tod_sec), .tod_subsec(tod_subsec)
  );

  // monitor: each negedge compares the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (tod_sec !== e.s || tod_subsec !== e.ns) begin
          errors++;
          $display("FAIL %s: time (%0d,%0d) expected (%0d,%0d)",
                   e.req, tod_sec, tod_subsec, e.s, e.ns);
        end
      end
    end
  end

  task automatic step1();
    @(negedge clk);
    #0.5;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step1();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step1();
    wr_en = 1'b0;
  endtask

  // expectation for the value after the next unconsumed clock edge
  task automatic expect_t(input string req, input logic [31:0] s, input logic [30:0] ns);
    exp_t e;
    e.req = req; e.s = s; e.ns = ns;
    sb_q.push_back(e);
  endtask

  task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #0.5;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d read %0h expected %0h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    steps(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd("R1", RC, 32'h0);
    chk_rd("R1", RTS, 32'h0);
    expect_t("R1", 0, 0); step1();

    // R5 time load, decimal mode, self-clearing bit
    wr(RC, 32'h2);
    wr(RSEC, 5);
    wr(RSUB, 999_999_990);
    wr(RC, 32'h6);
    chk_rd("R5", RC, 32'h6);
    expect_t("R5", 5, 999_999_990); step1();
    chk_rd("R5", RC, 32'h2);

    // R2 coarse decimal stepping with wrap
    wr(RS, 4);
    expect_t("R2", 5, 999_999_994);
    expect_t("R2", 5, 999_999_998);
    expect_t("R2", 6, 2);
    expect_t("R2", 6, 6);
    steps(4);
    wr(RS, 0);
    expect_t("R2", 6, 10); step1();

    // R7 offset add with carry
    wr(RSEC, 3);
    wr(RSUB, 999_999_995);
    wr(RC, 32'hA);
    expect_t("R7", 10, 5); step1();
    chk_rd("R7", RTS, 10);
    chk_rd("R7", RTN, 5);

    // R8 subtract with borrow, then without borrow
    wr(RSEC, 32'hFFFF_FFFE);
    wr(RSUB, 32'h8000_0000 | (BIL - 7));
    wr(RC, 32'hA);
    expect_t("R8", 7, 999_999_998); step1();
    wr(RSEC, 32'hFFFF_FFFF);
    wr(RSUB, 32'h8000_0000 | (BIL - 500));
    wr(RC, 32'hA);
    expect_t("R8", 6, 999_999_498); step1();

    // R10 commands suppress the step while running
    wr(RSEC, 100);
    wr(RSUB, 50);
    wr(RS, 4);
    wr(RC, 32'h6);
    expect_t("R10", 100, 50);
    expect_t("R2", 100, 54);
    steps(2);
    wr(RSEC, 1);
    wr(RSUB, 2);
    wr(RC, 32'hA);
    expect_t("R10", 101, 68);
    expect_t("R2", 101, 72);
    steps(2);
    wr(RS, 0);
    expect_t("R2", 101, 76); step1();

    // R3 binary rollover at 2^31
    wr(RSEC, 0);
    wr(RSUB, 32'h7FFF_FFFD);
    wr(RC, 32'h4);
    expect_t("R5", 0, 31'h7FFF_FFFD); step1();
    wr(RS, 2);
    expect_t("R3", 0, 31'h7FFF_FFFF);
    expect_t("R3", 1, 1);
    expect_t("R3", 1, 3);
    steps(3);
    wr(RS, 0);
    expect_t("R3", 1, 5); step1();

    // R9 priority of simultaneous commands
    wr(RSEC, 20);
    wr(RSUB, 100);
    wr(RC, 32'h1C);
    chk_rd("R9", RC, 32'h1C);
    expect_t("R9", 20, 100); step1();
    chk_rd("R9", RC, 32'h18);
    expect_t("R9", 40, 200); step1();
    chk_rd("R9", RC, 32'h10);
    expect_t("R9", 40, 200); step1();
    chk_rd("R9", RC, 32'h0);

    // R6 staged addend inert, then R4 fine-mode advance
    wr(RC, 32'h1);
    wr(RADD, 32'h8000_0000);
    wr(RS, 6);
    expect_t("R6", 40, 200);
    expect_t("R6", 40, 200);
    steps(2);
    wr(RC, 32'h11);
    expect_t("R6", 40, 200);
    expect_t("R4", 40, 200);
    expect_t("R4", 40, 206);
    expect_t("R4", 40, 206);
    expect_t("R4", 40, 212);
    steps(5);
    chk_rd("R6", RC, 32'h1);

    while (sb_q.size() > 0) step1();
    step1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule